// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block takes four asynchronous interrupt pins from outside the chip and turns each one into a clean, maskable interrupt request for the processor. Each pin first crosses into the core clock domain through a two-stage synchronizer. A per-line trigger mode then decides when the line requests service. The choices are an active-high or active-low level, a rising edge, a falling edge, or any change of the pin.

All settings sit in a single configuration word that software writes and reads back. Edge-triggered lines remember an event in a sticky flag until software acknowledges it. It does so by writing a one to that line's self-clearing acknowledge bit. Level-triggered lines need no acknowledge, because their request simply follows the pin. Line 0 drives processor interrupt input 3, line 1 drives input 4, and so on up to input 6. The remaining processor inputs stay low.

Top module: `eic_ctrl`

## Requirements
- R1: A pin change reaches a level-mode output after exactly two rising clock edges, and is not visible after the first.
- R2: With the level bit at 1, polarity 1 makes the line request while the synchronized pin is 1, and polarity 0 makes it request while the pin is 0.
- R3: With the level bit at 0 and the any-change bit at 0, polarity 1 latches rising edges only and polarity 0 latches falling edges only.
- R4: With the level bit at 0 and the any-change bit at 1, both edges are latched, whatever the polarity bit holds.
- R5: A latched edge holds its request until a write with that line's acknowledge bit at 1. If a new edge arrives in the same cycle as the acknowledge, the latch stays set.
- R6: A line whose enable bit is 0 drives no request. Edges that arrive while a line is disabled are still latched, and they appear as soon as the line is enabled.
- R7: After reset all enable bits are 0 and every line is in active-low level mode. The word reads 0x00000F00, and no processor input is asserted.
- R8: Configuration word fields, with bit i for line i: enable [3:0], acknowledge [7:4], level [11:8], polarity [15:12], any-change [19:16]. The acknowledge field and bits [31:20] always read 0. The other fields read back as written.
- R9: In level mode no edge is latched, and writing the acknowledge bit has no effect on the request.
- R10: Lines 0 to 3 drive processor interrupt bits 3 to 6. Bits 0, 1, 2 and 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin_i | input | 4 | Asynchronous external interrupt pins, bit i is line i |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| cpu_irq_o | output | 8 | Processor interrupt inputs |

## Verification
The embedded properties watch every cycle for four things. A disabled line must never request. A level-mode line's request must track its synchronized pin. A detected edge must set the sticky flag on the next edge, and that flag rises only after a detected edge. An acknowledge without a coincident edge drops the flag, and level mode keeps it empty. Some behaviour is visible only through the bench's scenarios, because it spans several writes and pin changes:
- the two-edge synchronizer latency;
- the register layout and reset value;
- the decoding of all five trigger modes;
- the release of edges caught while masked;
- the edge that coincides with an acknowledge.

// File: rtl/eic_pkg.sv
package eic_pkg;

  // Per-line trigger and gating configuration.
  typedef struct packed {
    logic en;    // request enable (mask)
    logic lvl;   // 1: level trigger, 0: edge trigger
    logic pol;   // level: active value; single edge: 1 rising, 0 falling
    logic both;  // edge mode: trigger on any change
  } line_cfg_t;

endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic stage1_q;
  logic stage2_q;

  // Asserts at once, releases on the second clock edge after deassertion.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;

endmodule

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign pin_o = sync_q;

endmodule

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
  import eic_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output line_cfg_t [N-1:0]     cfg_o,
  output logic [N-1:0]          ack_o
);

  localparam int F_EN   = 0;
  localparam int F_ACK  = N;
  localparam int F_LVL  = 2 * N;
  localparam int F_POL  = 3 * N;
  localparam int F_BOTH = 4 * N;
  localparam int USED   = 5 * N;

  logic [N-1:0] en_q,   en_d;
  logic [N-1:0] lvl_q,  lvl_d;
  logic [N-1:0] pol_q,  pol_d;
  logic [N-1:0] both_q, both_d;

  // Next-state decode of the write word.
  always_comb begin
    en_d   = wdata_i[F_EN   +: N];
    lvl_d  = wdata_i[F_LVL  +: N];
    pol_d  = wdata_i[F_POL  +: N];
    both_d = wdata_i[F_BOTH +: N];
  end

  // Stored fields, loaded only on a write strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lvl_q  <= '1;
      pol_q  <= '0;
      both_q <= '0;
    end else if (we_i) begin
      en_q   <= en_d;
      lvl_q  <= lvl_d;
      pol_q  <= pol_d;
      both_q <= both_d;
    end
  end

  // Acknowledge is a one-cycle pulse taken straight from the write.
  assign ack_o = we_i ? wdata_i[F_ACK +: N] : '0;

  always_comb begin
    rdata_o                 = '0;
    rdata_o[F_EN   +: N]    = en_q;
    rdata_o[F_LVL  +: N]    = lvl_q;
    rdata_o[F_POL  +: N]    = pol_q;
    rdata_o[F_BOTH +: N]    = both_q;
  end

  for (genvar i = 0; i < N; i++) begin : g_cfg
    assign cfg_o[i] = '{en: en_q[i], lvl: lvl_q[i], pol: pol_q[i], both: both_q[i]};
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata_i[DW-1:USED];

endmodule

// File: rtl/eic_line_det.sv
module eic_line_det
  import eic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cfg_t cfg_i,
  input  logic      ack_i,
  input  logic      pin_i,
  output logic      irq_o
);

  logic prev_q;
  logic latch_q, latch_d, latch_en;
  logic rise, fall, edge_hit;

  always_comb begin
    rise = pin_i & ~prev_q;
    fall = ~pin_i & prev_q;
    if (cfg_i.lvl)       edge_hit = 1'b0;
    else if (cfg_i.both) edge_hit = rise | fall;
    else                 edge_hit = cfg_i.pol ? rise : fall;
  end

  // A fresh edge wins over an acknowledge; level mode empties the latch.
  always_comb begin
    latch_en = edge_hit | ack_i | cfg_i.lvl;
    if (cfg_i.lvl)     latch_d = 1'b0;
    else if (edge_hit) latch_d = 1'b1;
    else               latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (latch_en) latch_q <= latch_d;
    end
  end

  assign irq_o = cfg_i.en & (cfg_i.lvl ? (pin_i == cfg_i.pol) : latch_q);

  p_edge_sets_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> latch_q);

  p_latch_source_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(edge_hit));

  p_ack_drops_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && ack_i && !edge_hit) |=> !latch_q);

  p_level_empty_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.lvl |=> !latch_q);

endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int N        = 4,
  parameter int DW       = 32,
  parameter int CPU_W    = 8,
  parameter int CPU_BASE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ext_pin_i,
  input  logic             cfg_we_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [DW-1:0]    cfg_rdata_o,
  output logic [CPU_W-1:0] cpu_irq_o
);

  logic             rst_n_s;
  logic [N-1:0]     pin_s;
  logic [N-1:0]     ack;
  logic [N-1:0]     line_irq;
  line_cfg_t [N-1:0] cfg;

  eic_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  eic_pin_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .pin_i (ext_pin_i),
    .pin_o (pin_s)
  );

  eic_cfg_regs #(.N(N), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg),
    .ack_o   (ack)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    eic_line_det u_det (
      .clk   (clk),
      .rst_n (rst_n_s),
      .cfg_i (cfg[i]),
      .ack_i (ack[i]),
      .pin_i (pin_s[i]),
      .irq_o (line_irq[i])
    );

    p_mask_gate_r6 : assert property (@(posedge clk) disable iff (!rst_n_s)
      !cfg[i].en |-> !cpu_irq_o[CPU_BASE+i]);

    p_level_follow_r2 : assert property (@(posedge clk) disable iff (!rst_n_s)
      (cfg[i].en && cfg[i].lvl) |-> (cpu_irq_o[CPU_BASE+i] == (pin_s[i] == cfg[i].pol)));
  end

  // Line i lands on processor input CPU_BASE+i; all other inputs idle.
  always_comb begin
    cpu_irq_o = '0;
    for (int i = 0; i < N; i++) cpu_irq_o[CPU_BASE+i] = line_irq[i];
  end

endmodule

// File: tb/eic_ctrl_test.sv
`timescale 1ns/1ps
module eic_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pins;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  cpu;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eic_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_pin_i   (pins),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .cpu_irq_o   (cpu)
  );

  typedef struct packed {
    logic        wr;
    logic [19:0] word;
    logic [3:0]  pin;
    logic [3:0]  exp;
  } vec_t;

  // Modes A: L0 rising, L1 falling, L2 any change, L3 active-high level.
  localparam vec_t VEC [12] = '{
    '{1'b1, 20'h4980F, 4'h0, 4'h6}, // R3 R4: falling on L1, change on L2
    '{1'b1, 20'h498FF, 4'h0, 4'h0}, // R5 acknowledge all
    '{1'b0, 20'h00000, 4'hF, 4'hD}, // R3 R2: rising L0, change L2, high L3
    '{1'b1, 20'h498FF, 4'hF, 4'h8}, // R5 acknowledge leaves level line
    '{1'b0, 20'h00000, 4'h0, 4'h6}, // R3 R4 falling pattern
    '{1'b1, 20'h498F0, 4'h0, 4'h0}, // R6 mask all and acknowledge
    '{1'b1, 20'h49800, 4'hF, 4'h0}, // R6 edges while masked
    '{1'b1, 20'h4980F, 4'hF, 4'hD}, // R6 masked edges released
    '{1'b1, 20'h00FFF, 4'hA, 4'h5}, // R2 active-low level
    '{1'b1, 20'h00FFF, 4'hA, 4'h5}, // R9 acknowledge ignored in level mode
    '{1'b1, 20'h360FF, 4'h5, 4'hF}, // R4 change with both polarities, R3
    '{1'b1, 20'h360FF, 4'h5, 4'h0}  // R5 acknowledge all
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [19:0] word, input logic [3:0] pin);
    @(negedge clk);
    we    = wr;
    wdata = {12'h000, word};
    pins  = pin;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    pins  = 4'hF;
    we    = 1'b0;
    wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    check("R7 reset word", rdata, 32'h0000_0F00);
    check("R7 reset outputs", {24'h0, cpu}, 32'h0);

    foreach (VEC[k]) begin
      step(VEC[k].wr, VEC[k].word, VEC[k].pin);
      check($sformatf("R2-mode vector %0d lines", k), {28'h0, cpu[6:3]}, {28'h0, VEC[k].exp});
      check($sformatf("R10 vector %0d idle bits", k), {24'h0, cpu & 8'h87}, 32'h0);
    end

    // R8: acknowledge field reads 0, others read back
    step(1'b1, 20'h498FF, 4'h5);
    check("R8 readback", rdata, 32'h0004_980F);

    // R1: level high on L3 only, latency of two edges
    step(1'b1, 20'h08808, 4'h0);
    @(negedge clk);
    pins = 4'h8;
    @(posedge clk);
    @(negedge clk);
    check("R1 after one edge", {31'h0, cpu[6]}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R1 after two edges", {31'h0, cpu[6]}, 32'h1);

    // R5: acknowledge coinciding with a new edge keeps the latch
    step(1'b1, 20'h010F1, 4'h0);
    check("R3 rising setup", {31'h0, cpu[3]}, 32'h0);
    step(1'b0, 20'h0, 4'h1);
    check("R3 rising latched", {31'h0, cpu[3]}, 32'h1);
    step(1'b0, 20'h0, 4'h0);
    check("R3 falling ignored", {31'h0, cpu[3]}, 32'h1);
    @(negedge clk);
    pins = 4'h1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    we    = 1'b1;
    wdata = 32'h0001_00F1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R5 edge beats acknowledge", {31'h0, cpu[3]}, 32'h1);
    step(1'b1, 20'h010F1, 4'h1);
    check("R5 acknowledge clears", {31'h0, cpu[3]}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule